// File: doc/BRIEF.md
# Privileged Instruction Trap Decider

This block sits beside the decode stage of a hart that supports supervisor and hypervisor privilege levels. When a wait-for-interrupt, an address-translation fence, a virtual-machine hypervisor fence or a guest-physical hypervisor fence reaches it, the block works out what happens to that instruction. The outcome is one of four: the hart proceeds and halts, the hart performs a local translation-cache flush, the hart takes an illegal-instruction exception, or the hart takes a virtual-instruction fault.

The decision uses several inputs:

- the current privilege level;
- the virtualization state;
- whether supervisor mode and the hypervisor extension are implemented;
- four status trap controls: the timeout-wait bit, the trap-virtual-memory bit, and the virtual counterparts of both.

The outcome is registered and is presented one cycle after a valid request. A separate single-cycle halt strobe marks a wait that is allowed to stall the hart.

Top module: `priv_trap_decider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `res_valid_o`, `res_code_o` and `halt_o` are all zero.
- R2: A request sampled with `req_valid_i` high produces `res_valid_o` high on the next cycle, carrying a code in which 0 = proceed/halt, 1 = flush, 2 = illegal instruction and 3 = virtual-instruction fault. A cycle with `req_valid_i` low produces `res_valid_o` low, code 0 and `halt_o` low on the next cycle.
- R3: A wait (`req_op_i` = 0) is illegal in either of two cases. The first is when the timeout-wait bit is set and the hart is in supervisor mode (`priv_i` = 1), or in user mode (`priv_i` = 0) with no supervisor mode implemented. The second is when supervisor mode is implemented and the hart is in user mode without effective virtualization.
- R4: A wait that is not illegal gives a virtual-instruction fault when virtualization is effective and the hart is either in user mode, or in supervisor mode with the virtual timeout-wait bit set.
- R5: A wait that neither R3 nor R4 rejects gives code 0, and `halt_o` pulses high for exactly that one result cycle. `halt_o` is never high for any other operation or outcome.
- R6: An address-translation fence (`req_op_i` = 1) is illegal in user mode, and in supervisor mode when the trap-virtual-memory bit is set.
- R7: An address-translation fence that is not illegal gives a virtual-instruction fault when virtualization is effective and the virtual trap-VM bit is set. Otherwise it gives flush.
- R8: A hypervisor fence (`req_op_i` = 2) gives a virtual-instruction fault in virtualized supervisor mode. It gives flush in machine mode or non-virtualized supervisor mode, and illegal in every user-mode case.
- R9: A guest-physical hypervisor fence (`req_op_i` = 3) is illegal in non-virtualized supervisor mode when the trap-virtual-memory bit is set. Otherwise it follows R8 exactly.
- R10: Virtualization is effective only when `virt_i` is high, the hypervisor is implemented and the hart is not in machine mode. A `priv_i` value of 2 or 3 counts as machine mode. When virtualization is not effective, `virt_i` has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | Operation: 0 wait, 1 address fence, 2 hypervisor fence, 3 guest-physical hypervisor fence |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 2/3 machine |
| virt_i | input | 1 | Hart is running virtualized |
| sup_present_i | input | 1 | Supervisor mode implemented |
| hyp_present_i | input | 1 | Hypervisor extension implemented |
| trap_wait_i | input | 1 | Timeout-wait trap control |
| trap_vm_i | input | 1 | Trap-virtual-memory control |
| virt_trap_wait_i | input | 1 | Virtual timeout-wait trap control |
| virt_trap_vm_i | input | 1 | Virtual trap-VM control |
| res_valid_o | output | 1 | Outcome valid |
| res_code_o | output | 2 | Outcome code |
| halt_o | output | 1 | Single-cycle halt strobe |

## Verification
Each operation is driven through every combination of privilege level, virtualization flag, implementation flags and all four trap controls. This covers every precedence boundary: illegal over virtual fault, and each fault over flush or halt. Targeted cases hold all inputs fixed and toggle only `virt_i`, in machine mode and with no hypervisor. These cases show that the virtualization gate works independently of the per-operation rules. Idle cycles after a halting wait show that the halt strobe lasts only one cycle, and that no stale outcome appears without a request.

// File: rtl/ptd_pkg.sv
package ptd_pkg;

    localparam int OP_W   = 2;
    localparam int PRIV_W = 2;
    localparam int CODE_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_WAIT     = 2'd0,
        OP_ATFENCE  = 2'd1,
        OP_HFENCE_V = 2'd2,
        OP_HFENCE_G = 2'd3
    } op_e;

    typedef enum logic [CODE_W-1:0] {
        OUT_PROCEED = 2'd0,
        OUT_FLUSH   = 2'd1,
        OUT_ILLEGAL = 2'd2,
        OUT_VFAULT  = 2'd3
    } outcome_e;

    typedef struct packed {
        logic     valid;
        outcome_e code;
        logic     halt;
    } result_t;

endpackage

// File: rtl/ptd_mode.sv
module ptd_mode
    import ptd_pkg::*;
(
    input  logic [PRIV_W-1:0] priv_i,
    input  logic              virt_i,
    input  logic              hyp_present_i,
    output logic              is_u_o,
    output logic              is_s_o,
    output logic              is_m_o,
    output logic              virt_eff_o
);
    always_comb begin
        is_u_o     = (priv_i == PRIV_W'(0));
        is_s_o     = (priv_i == PRIV_W'(1));
        is_m_o     = priv_i[PRIV_W-1];
        virt_eff_o = virt_i & hyp_present_i & ~is_m_o;
    end
endmodule

// File: rtl/ptd_wait.sv
module ptd_wait
    import ptd_pkg::*;
(
    input  logic     is_u_i,
    input  logic     is_s_i,
    input  logic     virt_i,
    input  logic     sup_present_i,
    input  logic     trap_wait_i,
    input  logic     virt_trap_wait_i,
    output outcome_e code_o
);
    logic tw_hit;
    logic user_bare;
    logic vf_hit;

    always_comb begin
        tw_hit    = trap_wait_i & (is_s_i | (~sup_present_i & is_u_i));
        user_bare = sup_present_i & is_u_i & ~virt_i;
        vf_hit    = virt_i & (is_u_i | (is_s_i & virt_trap_wait_i));
        if (tw_hit || user_bare) begin
            code_o = OUT_ILLEGAL;
        end else if (vf_hit) begin
            code_o = OUT_VFAULT;
        end else begin
            code_o = OUT_PROCEED;
        end
    end
endmodule

// File: rtl/ptd_atfence.sv
module ptd_atfence
    import ptd_pkg::*;
(
    input  logic     is_u_i,
    input  logic     is_s_i,
    input  logic     virt_i,
    input  logic     trap_vm_i,
    input  logic     virt_trap_vm_i,
    output outcome_e code_o
);
    always_comb begin
        if (is_u_i || (is_s_i && trap_vm_i)) begin
            code_o = OUT_ILLEGAL;
        end else if (virt_i && virt_trap_vm_i) begin
            code_o = OUT_VFAULT;
        end else begin
            code_o = OUT_FLUSH;
        end
    end
endmodule

// File: rtl/ptd_hfence.sv
module ptd_hfence
    import ptd_pkg::*;
#(
    parameter bit GUEST_PHYS = 1'b0
) (
    input  logic     is_s_i,
    input  logic     is_m_i,
    input  logic     virt_i,
    input  logic     trap_vm_i,
    output outcome_e code_o
);
    logic pre_illegal;

    generate
        if (GUEST_PHYS) begin : g_gpa
            assign pre_illegal = is_s_i & ~virt_i & trap_vm_i;
        end else begin : g_vma
            logic unused_tvm;
            assign unused_tvm  = trap_vm_i;
            assign pre_illegal = 1'b0;
        end
    endgenerate

    always_comb begin
        if (pre_illegal) begin
            code_o = OUT_ILLEGAL;
        end else if (is_s_i && virt_i) begin
            code_o = OUT_VFAULT;
        end else if (is_m_i || (is_s_i && !virt_i)) begin
            code_o = OUT_FLUSH;
        end else begin
            code_o = OUT_ILLEGAL;
        end
    end
endmodule

// File: rtl/priv_trap_decider.sv
module priv_trap_decider
    import ptd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [OP_W-1:0]   req_op_i,
    input  logic [PRIV_W-1:0] priv_i,
    input  logic              virt_i,
    input  logic              sup_present_i,
    input  logic              hyp_present_i,
    input  logic              trap_wait_i,
    input  logic              trap_vm_i,
    input  logic              virt_trap_wait_i,
    input  logic              virt_trap_vm_i,
    output logic              res_valid_o,
    output logic [CODE_W-1:0] res_code_o,
    output logic              halt_o
);
    logic     is_u, is_s, is_m, virt_eff;
    outcome_e wait_code, at_code, hv_code, hg_code, sel_code;
    result_t  res_d, res_q;

    ptd_mode u_mode (
        .priv_i        (priv_i),
        .virt_i        (virt_i),
        .hyp_present_i (hyp_present_i),
        .is_u_o        (is_u),
        .is_s_o        (is_s),
        .is_m_o        (is_m),
        .virt_eff_o    (virt_eff)
    );

    ptd_wait u_wait (
        .is_u_i           (is_u),
        .is_s_i           (is_s),
        .virt_i           (virt_eff),
        .sup_present_i    (sup_present_i),
        .trap_wait_i      (trap_wait_i),
        .virt_trap_wait_i (virt_trap_wait_i),
        .code_o           (wait_code)
    );

    ptd_atfence u_atfence (
        .is_u_i         (is_u),
        .is_s_i         (is_s),
        .virt_i         (virt_eff),
        .trap_vm_i      (trap_vm_i),
        .virt_trap_vm_i (virt_trap_vm_i),
        .code_o         (at_code)
    );

    ptd_hfence #(.GUEST_PHYS(1'b0)) u_hfence_v (
        .is_s_i    (is_s),
        .is_m_i    (is_m),
        .virt_i    (virt_eff),
        .trap_vm_i (trap_vm_i),
        .code_o    (hv_code)
    );

    ptd_hfence #(.GUEST_PHYS(1'b1)) u_hfence_g (
        .is_s_i    (is_s),
        .is_m_i    (is_m),
        .virt_i    (virt_eff),
        .trap_vm_i (trap_vm_i),
        .code_o    (hg_code)
    );

    always_comb begin
        unique case (op_e'(req_op_i))
            OP_WAIT:     sel_code = wait_code;
            OP_ATFENCE:  sel_code = at_code;
            OP_HFENCE_V: sel_code = hv_code;
            OP_HFENCE_G: sel_code = hg_code;
            default:     sel_code = OUT_ILLEGAL;
        endcase

        res_d.valid = req_valid_i;
        res_d.code  = req_valid_i ? sel_code : OUT_PROCEED;
        res_d.halt  = req_valid_i && (op_e'(req_op_i) == OP_WAIT)
                      && (sel_code == OUT_PROCEED);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            res_q <= '{valid: 1'b0, code: OUT_PROCEED, halt: 1'b0};
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid_o = res_q.valid;
    assign res_code_o  = res_q.code;
    assign halt_o      = res_q.halt;
endmodule

// File: rtl/ptd_chk.sv
module ptd_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       req_valid_i,
    input logic [1:0] req_op_i,
    input logic [1:0] priv_i,
    input logic       virt_i,
    input logic       sup_present_i,
    input logic       hyp_present_i,
    input logic       trap_vm_i,
    input logic       res_valid_o,
    input logic [1:0] res_code_o,
    input logic       halt_o
);
    logic veff;
    assign veff = virt_i & hyp_present_i & ~priv_i[1];

    // R2
    req_to_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> res_valid_o);

    // R2
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> (!res_valid_o && !halt_o && res_code_o == 2'd0));

    // R5
    halt_only_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |-> (res_valid_o && res_code_o == 2'd0 && $past(req_op_i) == 2'd0));

    // R3
    wait_user_bare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_op_i == 2'd0 && priv_i == 2'd0 && sup_present_i && !veff)
        |=> res_code_o == 2'd2);

    // R6
    fence_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_op_i == 2'd1 && priv_i == 2'd0) |=> res_code_o == 2'd2);

    // R8
    hfence_mach_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_op_i == 2'd2 && priv_i[1]) |=> res_code_o == 2'd1);

    // R9
    gfence_tvm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_op_i == 2'd3 && priv_i == 2'd1 && !veff && trap_vm_i)
        |=> res_code_o == 2'd2);
endmodule

bind priv_trap_decider ptd_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_op_i      (req_op_i),
    .priv_i        (priv_i),
    .virt_i        (virt_i),
    .sup_present_i (sup_present_i),
    .hyp_present_i (hyp_present_i),
    .trap_vm_i     (trap_vm_i),
    .res_valid_o   (res_valid_o),
    .res_code_o    (res_code_o),
    .halt_o        (halt_o)
);

// File: tb/priv_trap_decider_tb.sv
`timescale 1ns/1ps
module priv_trap_decider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [1:0] priv = 2'd0;
    logic       virt = 1'b0, sup_p = 1'b0, hyp_p = 1'b0;
    logic       tw = 1'b0, tvm = 1'b0, vtw = 1'b0, vtvm = 1'b0;
    logic       res_valid;
    logic [1:0] res_code;
    logic       halt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    priv_trap_decider u_dut (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
        .priv_i(priv), .virt_i(virt), .sup_present_i(sup_p), .hyp_present_i(hyp_p),
        .trap_wait_i(tw), .trap_vm_i(tvm), .virt_trap_wait_i(vtw),
        .virt_trap_vm_i(vtvm), .res_valid_o(res_valid), .res_code_o(res_code),
        .halt_o(halt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (op=%0d priv=%0d v=%0d s=%0d h=%0d tw=%0d tvm=%0d vtw=%0d vtvm=%0d)",
                     tag, act, exp, req_op, priv, virt, sup_p, hyp_p, tw, tvm, vtw, vtvm);
        end
    endtask

    // Expected outcome built from the requirement text.
    function automatic int expect_code(input int op, input int p, input bit v,
                                       input bit s, input bit h, input bit t_w,
                                       input bit t_vm, input bit vt_w, input bit vt_vm);
        bit mach = (p >= 2);
        bit sup  = (p == 1);
        bit usr  = (p == 0);
        bit ve   = v && h && !mach;        // R10
        case (op)
            0: begin
                if (t_w && (sup || (usr && !s))) return 2;   // R3
                if (s && usr && !ve) return 2;                // R3
                if (ve && (usr || (sup && vt_w))) return 3;   // R4
                return 0;                                     // R5
            end
            1: begin
                if (usr || (sup && t_vm)) return 2;           // R6
                if (ve && vt_vm) return 3;                    // R7
                return 1;
            end
            default: begin
                if (op == 3 && sup && !ve && t_vm) return 2;  // R9
                if (sup && ve) return 3;                      // R8
                if (mach || sup) return 1;
                return 2;
            end
        endcase
    endfunction

    task automatic issue(input int op, input int idx);
        @(negedge clk);
        req_valid = 1'b1;
        req_op = 2'(op);
        priv = idx[1:0];
        virt = idx[2]; sup_p = idx[3]; hyp_p = idx[4];
        tw = idx[5]; tvm = idx[6]; vtw = idx[7]; vtvm = idx[8];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic sweep(input int op, input string tag);
        for (int i = 0; i < 512; i++) begin
            int e;
            issue(op, i);
            e = expect_code(op, i[1:0], i[2], i[3], i[4], i[5], i[6], i[7], i[8]);
            chk({tag, " valid"}, res_valid, 1);
            chk({tag, " code"}, res_code, e);
            chk({tag, " halt R5"}, halt, (op == 0 && e == 0) ? 1 : 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        req_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valid in reset", res_valid, 0);
        chk("R1 code in reset", res_code, 0);
        chk("R1 halt in reset", halt, 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", res_valid, 0);
        chk("R1 halt after reset", halt, 0);
    endtask

    task automatic t_wait();         sweep(0, "R3/R4 wait"); endtask
    task automatic t_atfence();      sweep(1, "R6/R7 fence"); endtask
    task automatic t_hfence();       sweep(2, "R8 hfence"); endtask
    task automatic t_gfence();       sweep(3, "R9 gfence"); endtask

    task automatic t_pulse_idle();
        // halting wait: supervisor, no traps
        issue(0, 1 | (1 << 3));
        chk("R5 halt pulse", halt, 1);
        chk("R5 halt code", res_code, 0);
        @(negedge clk);
        chk("R5 halt one cycle", halt, 0);
        chk("R2 idle valid", res_valid, 0);
        chk("R2 idle code", res_code, 0);
    endtask

    task automatic t_virt_gate();
        // R10: machine mode, hypervisor present, virt toggled
        issue(1, 3 | (1 << 4) | (1 << 8));
        chk("R10 machine virt=0", res_code, 1);
        issue(1, 3 | (1 << 2) | (1 << 4) | (1 << 8));
        chk("R10 machine virt=1", res_code, 1);
        // R10: no hypervisor, supervisor, virt toggled on hfence
        issue(2, 1 | (1 << 3));
        chk("R10 nohyp virt=0", res_code, 1);
        issue(2, 1 | (1 << 2) | (1 << 3));
        chk("R10 nohyp virt=1", res_code, 1);
        // R10: wait in user mode, no hypervisor, virt set is still illegal
        issue(0, 0 | (1 << 2) | (1 << 3));
        chk("R10 nohyp wait user", res_code, 2);
    endtask

    initial begin
        t_reset();
        t_pulse_idle();
        t_wait();
        t_atfence();
        t_hfence();
        t_gfence();
        t_virt_gate();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule